// File: doc/BRIEF.md
# Seconds Counter with Alarm Compare

This block keeps wall-clock time as a single long count advanced by a slow tick of about 32 kHz. The count has two parts: a whole-seconds word and a 15-bit sub-second fraction. When the fraction rolls over, the seconds word steps by one. A second register pair of the same shape holds an alarm time. When the running count arrives at that time, a sticky flag is raised. An interrupt line reports that flag and the two flags that reset leaves set, each gated by its own enable bit.

Software reaches every register through a simple single-cycle register port. Writes are strobed, and reads are combinational from the address. The counter is deliberately inert after reset. It will not move until software has set its run bit and has also loaded the seconds word at least once. Reset leaves the invalid-state flag and the security flag set, so software has to acknowledge them before it can trust the time. Every status flag is cleared by writing a 1 to its bit.

The tick input is a one-cycle pulse that is already synchronous to the register clock.

Top module: `rtc_alarm_top`

## Requirements
- R1: After reset the count seconds and fraction read 0, the alarm seconds reads 0xFFFFFFFF, the alarm fraction reads 0, control reads 0, status reads 0x3 (bits 1 and 0 set), interrupt enable reads 0, and `irq` is low.
- R2: The count holds its value unless control bit 3 (run) is 1 and the seconds word (offset 0x00) has been written at least once since reset.
- R3: On each tick while running, the fraction (offset 0x04, bits 14:0) increments by 1. When it goes from 0x7FFF to 0, the seconds word increments by 1 on that same tick.
- R4: A bus write to the count seconds or count fraction loads that word. If a tick arrives in the same cycle as either of these writes, the write wins and the count does not advance in that cycle.
- R5: Status bit 4 (alarm) is set on the tick that advances the count to a value equal to the alarm seconds (offset 0x08) and the alarm fraction (offset 0x0C). It is never set while the alarm seconds is 0xFFFFFFFF.
- R6: The alarm flag stays set until a status write (offset 0x14) carries 1 in bit 4. Writing 0 there leaves it set. A new match in the same cycle as the clear keeps it set.
- R7: Status bit 1 (invalid) and bit 0 (security) each clear only when a status write carries 1 in that bit. Otherwise they keep their value.
- R8: `irq` is high exactly while some status flag at bit 4, 1 or 0 is set and the bit at the same position of the interrupt-enable register (offset 0x18) is also set.
- R9: Control sits at offset 0x10, with run in bit 3. A read of any offset outside 0x00 to 0x18 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse per 32 kHz period, synchronous to clk |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The counter is first driven with ticks while only one of its two start conditions holds, and then while both hold. This separates the run bit from the "seconds written" requirement. Fraction values placed just below 0x7FFF show that the carry into seconds happens on the wrapping tick. A write that lands in the same cycle as a tick shows that the write takes priority. The alarm is tried with a reachable target, with the "no alarm" seconds value, and with a clear that lands on the match cycle. Each flag is cleared on its own, to show that a clear touches only the bit it names and that only enabled flags reach `irq`.

// File: rtl/rtc_pkg.sv
// Package: register offsets and bit positions shared by the block and its bench.
package rtc_pkg;
    localparam int          ADDR_W       = 5;
    localparam int          DATA_W       = 32;
    localparam logic [4:0]  OFS_CNT_SEC  = 5'h00;
    localparam logic [4:0]  OFS_CNT_FRAC = 5'h04;
    localparam logic [4:0]  OFS_ALM_SEC  = 5'h08;
    localparam logic [4:0]  OFS_ALM_FRAC = 5'h0C;
    localparam logic [4:0]  OFS_CTRL     = 5'h10;
    localparam logic [4:0]  OFS_STAT     = 5'h14;
    localparam logic [4:0]  OFS_IEN      = 5'h18;
    localparam int          RUN_BIT      = 3;
    localparam int          ALARM_BIT    = 4;
    localparam int          INVAL_BIT    = 1;
    localparam int          SECV_BIT     = 0;
endpackage

// File: rtl/rtc_counter.sv
// Module: rtc_counter
// Keeps the seconds word and the sub-second fraction.
// The count moves by one on each tick, but only when run_en is set and the
// seconds word has been loaded at least once since reset. Loads from the bus
// take priority over a tick that arrives in the same cycle.
// Assumes that tick is a single-cycle pulse synchronous to clk.
module rtc_counter #(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run_en,
    input  logic              ld_sec,
    input  logic              ld_frac,
    input  logic [SEC_W-1:0]  wr_sec,
    input  logic [FRAC_W-1:0] wr_frac,
    output logic [SEC_W-1:0]  sec_q,
    output logic [FRAC_W-1:0] frac_q,
    output logic              adv,
    output logic [SEC_W-1:0]  nxt_sec,
    output logic [FRAC_W-1:0] nxt_frac
);
    logic seeded_q;

    // Work out the value after an advance, and whether this cycle advances.
    always_comb begin
        nxt_frac = frac_q + FRAC_W'(1);
        nxt_sec  = (&frac_q) ? sec_q + SEC_W'(1) : sec_q;
        adv      = tick && run_en && seeded_q && !ld_sec && !ld_frac;
    end

    // Count register: reset, bus load, or advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q    <= '0;
            frac_q   <= '0;
            seeded_q <= 1'b0;
        end else begin
            if (ld_sec) begin
                sec_q    <= wr_sec;
                seeded_q <= 1'b1;
            end
            if (ld_frac) frac_q <= wr_frac;
            if (adv) begin
                sec_q  <= nxt_sec;
                frac_q <= nxt_frac;
            end
        end
    end

    // The count holds while it is not running and is not being loaded.
    p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(run_en && seeded_q) && !ld_sec && !ld_frac)
        |=> (sec_q == $past(sec_q) && frac_q == $past(frac_q)));

    // A wrapping fraction carries into the seconds word on the same tick.
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && (&frac_q))
        |=> (frac_q == '0 && sec_q == $past(sec_q) + SEC_W'(1)));
endmodule

// File: rtl/rtc_alarm_cmp.sv
// Module: rtc_alarm_cmp
// Holds the alarm seconds and fraction registers.
// Raises hit on an advancing cycle when the value the count is moving to
// equals the alarm. An alarm seconds value of all ones disables matching.
module rtc_alarm_cmp #(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_sec,
    input  logic              ld_frac,
    input  logic [SEC_W-1:0]  wr_sec,
    input  logic [FRAC_W-1:0] wr_frac,
    input  logic              adv,
    input  logic [SEC_W-1:0]  nxt_sec,
    input  logic [FRAC_W-1:0] nxt_frac,
    output logic [SEC_W-1:0]  alm_sec_q,
    output logic [FRAC_W-1:0] alm_frac_q,
    output logic              hit
);
    logic armed;

    // Match detection against the value the count is about to take.
    always_comb begin
        armed = (alm_sec_q != '1);
        hit   = adv && armed && (nxt_sec == alm_sec_q) && (nxt_frac == alm_frac_q);
    end

    // Alarm registers: reset to "no alarm", then load from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm_sec_q  <= '1;
            alm_frac_q <= '0;
        end else begin
            if (ld_sec)  alm_sec_q  <= wr_sec;
            if (ld_frac) alm_frac_q <= wr_frac;
        end
    end
endmodule

// File: rtl/rtc_status_irq.sv
// Module: rtc_status_irq
// Holds the three status flags and the interrupt-enable bits, and drives the
// level interrupt. Flags are cleared by writing 1 to them. A set that arrives
// in the same cycle as a clear wins.
// Flag order in the vectors is {alarm, invalid, security}.
module rtc_status_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic [2:0] clr_mask,
    input  logic       ien_wr,
    input  logic [2:0] ien_wdata,
    output logic [2:0] flags_q,
    output logic [2:0] ien_q,
    output logic       irq
);
    // Flag register: set by an alarm hit, cleared by writing 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= 3'b011;
        end else begin
            flags_q[2] <= hit || (flags_q[2] && !clr_mask[2]);
            flags_q[1] <= flags_q[1] && !clr_mask[1];
            flags_q[0] <= flags_q[0] && !clr_mask[0];
        end
    end

    // Interrupt-enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= '0;
        else if (ien_wr) ien_q <= ien_wdata;
    end

    // Level interrupt from the enabled flags.
    always_comb irq = |(flags_q & ien_q);

    // The alarm flag is sticky unless a clear is written.
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[2] && !clr_mask[2]) |=> flags_q[2]);

    // The invalid flag only drops after a write of 1 to its bit.
    p_inval_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags_q[1]) |-> $past(clr_mask[1]));

    // With every enable bit off, no interrupt is raised.
    p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == 3'b000) |-> !irq);
endmodule

// File: rtl/rtc_alarm_top.sv
// Module: rtc_alarm_top
// Register front end for the seconds counter with alarm compare. It decodes
// strobed bus writes into load and clear controls, and muxes a combinational
// readback. Assumes 32-bit data words and byte offsets on bus_addr.
module rtc_alarm_top #(
    parameter int SEC_W  = 32,
    parameter int FRAC_W = 15
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    input  logic                      bus_wr,
    input  logic [rtc_pkg::ADDR_W-1:0] bus_addr,
    input  logic [rtc_pkg::DATA_W-1:0] bus_wdata,
    output logic [rtc_pkg::DATA_W-1:0] bus_rdata,
    output logic                      irq
);
    import rtc_pkg::*;

    logic              run_q;
    logic              ld_cnt_sec, ld_cnt_frac, ld_alm_sec, ld_alm_frac;
    logic              wr_ctrl, wr_stat, wr_ien;
    logic [2:0]        clr_mask, ien_wdata, flags_q, ien_q;
    logic [SEC_W-1:0]  sec_q, alm_sec_q, nxt_sec;
    logic [FRAC_W-1:0] frac_q, alm_frac_q, nxt_frac;
    logic              adv, hit;

    // Write decode.
    always_comb begin
        ld_cnt_sec  = bus_wr && (bus_addr == OFS_CNT_SEC);
        ld_cnt_frac = bus_wr && (bus_addr == OFS_CNT_FRAC);
        ld_alm_sec  = bus_wr && (bus_addr == OFS_ALM_SEC);
        ld_alm_frac = bus_wr && (bus_addr == OFS_ALM_FRAC);
        wr_ctrl     = bus_wr && (bus_addr == OFS_CTRL);
        wr_stat     = bus_wr && (bus_addr == OFS_STAT);
        wr_ien      = bus_wr && (bus_addr == OFS_IEN);
        clr_mask    = wr_stat ? {bus_wdata[ALARM_BIT], bus_wdata[INVAL_BIT], bus_wdata[SECV_BIT]} : 3'b000;
        ien_wdata   = {bus_wdata[ALARM_BIT], bus_wdata[INVAL_BIT], bus_wdata[SECV_BIT]};
    end

    // Control register: the run bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       run_q <= 1'b0;
        else if (wr_ctrl) run_q <= bus_wdata[RUN_BIT];
    end

    rtc_counter #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run_en(run_q),
        .ld_sec(ld_cnt_sec), .ld_frac(ld_cnt_frac),
        .wr_sec(bus_wdata[SEC_W-1:0]), .wr_frac(bus_wdata[FRAC_W-1:0]),
        .sec_q(sec_q), .frac_q(frac_q), .adv(adv),
        .nxt_sec(nxt_sec), .nxt_frac(nxt_frac)
    );

    rtc_alarm_cmp #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_alm (
        .clk(clk), .rst_n(rst_n),
        .ld_sec(ld_alm_sec), .ld_frac(ld_alm_frac),
        .wr_sec(bus_wdata[SEC_W-1:0]), .wr_frac(bus_wdata[FRAC_W-1:0]),
        .adv(adv), .nxt_sec(nxt_sec), .nxt_frac(nxt_frac),
        .alm_sec_q(alm_sec_q), .alm_frac_q(alm_frac_q), .hit(hit)
    );

    rtc_status_irq u_stat (
        .clk(clk), .rst_n(rst_n), .hit(hit), .clr_mask(clr_mask),
        .ien_wr(wr_ien), .ien_wdata(ien_wdata),
        .flags_q(flags_q), .ien_q(ien_q), .irq(irq)
    );

    // Readback mux; unmapped offsets read zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CNT_SEC:  bus_rdata[SEC_W-1:0]  = sec_q;
            OFS_CNT_FRAC: bus_rdata[FRAC_W-1:0] = frac_q;
            OFS_ALM_SEC:  bus_rdata[SEC_W-1:0]  = alm_sec_q;
            OFS_ALM_FRAC: bus_rdata[FRAC_W-1:0] = alm_frac_q;
            OFS_CTRL:     bus_rdata[RUN_BIT]    = run_q;
            OFS_STAT: begin
                bus_rdata[ALARM_BIT] = flags_q[2];
                bus_rdata[INVAL_BIT] = flags_q[1];
                bus_rdata[SECV_BIT]  = flags_q[0];
            end
            OFS_IEN: begin
                bus_rdata[ALARM_BIT] = ien_q[2];
                bus_rdata[INVAL_BIT] = ien_q[1];
                bus_rdata[SECV_BIT]  = ien_q[0];
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: tb/rtc_alarm_top_tb.sv
// Directed bench for rtc_alarm_top: one task per scenario.
module rtc_alarm_top_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    rtc_alarm_top dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One clock cycle: drive at negedge, sampled by the next posedge.
    task automatic cycle(input logic wr, input logic [4:0] a, input logic [31:0] d, input logic tk);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; tick = tk;
        @(negedge clk);
        bus_wr = 1'b0; tick = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        cycle(1'b1, a, d, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 5'h00, 32'h0, 1'b1);
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(5'h00, d); check("R1 cnt sec", d, 32'h0);
        rd(5'h04, d); check("R1 cnt frac", d, 32'h0);
        rd(5'h08, d); check("R1 alm sec", d, 32'hFFFF_FFFF);
        rd(5'h0C, d); check("R1 alm frac", d, 32'h0);
        rd(5'h10, d); check("R1 ctrl", d, 32'h0);
        rd(5'h14, d); check("R1 status", d, 32'h3);
        rd(5'h18, d); check("R1 ien", d, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_start_gate;
        logic [31:0] d;
        wr(5'h10, 32'h8);                     // run on, seconds never written
        ticks(4);
        rd(5'h04, d); check("R2 run without seed frac", d, 32'h0);
        wr(5'h10, 32'h0);
        wr(5'h00, 32'd10);                    // seeded but stopped
        ticks(3);
        rd(5'h04, d); check("R2 seeded stopped frac", d, 32'h0);
        rd(5'h10, d); check("R9 ctrl readback", d, 32'h0);
        wr(5'h10, 32'h8);
        rd(5'h10, d); check("R9 ctrl run bit", d, 32'h8);
        ticks(5);
        rd(5'h04, d); check("R3 frac counts", d, 32'd5);
        rd(5'h00, d); check("R3 sec unchanged", d, 32'd10);
    endtask

    task automatic t_wrap;
        logic [31:0] d;
        wr(5'h00, 32'd5);
        wr(5'h04, 32'h7FFE);
        ticks(1);
        rd(5'h04, d); check("R3 frac at max", d, 32'h7FFF);
        rd(5'h00, d); check("R3 sec before wrap", d, 32'd5);
        ticks(1);
        rd(5'h04, d); check("R3 frac wrapped", d, 32'h0);
        rd(5'h00, d); check("R3 sec carried", d, 32'd6);
    endtask

    task automatic t_write_priority;
        logic [31:0] d;
        cycle(1'b1, 5'h00, 32'd100, 1'b1);
        rd(5'h00, d); check("R4 sec load beats tick", d, 32'd100);
        rd(5'h04, d); check("R4 frac not advanced", d, 32'h0);
        cycle(1'b1, 5'h04, 32'h0123, 1'b1);
        rd(5'h04, d); check("R4 frac load beats tick", d, 32'h0123);
    endtask

    task automatic t_alarm;
        logic [31:0] d;
        wr(5'h18, 32'h10);
        wr(5'h08, 32'd20);
        wr(5'h0C, 32'd3);
        wr(5'h00, 32'd20);
        wr(5'h04, 32'd0);
        ticks(2);
        rd(5'h14, d); check("R5 no flag before match", d & 32'h10, 32'h0);
        check("R8 irq low before match", {31'h0, irq}, 32'h0);
        ticks(1);
        rd(5'h14, d); check("R5 flag on match", d & 32'h10, 32'h10);
        check("R8 irq on enabled alarm", {31'h0, irq}, 32'h1);
        ticks(3);
        rd(5'h14, d); check("R6 flag sticky past match", d & 32'h10, 32'h10);
        wr(5'h14, 32'h0);
        rd(5'h14, d); check("R6 write 0 keeps flag", d & 32'h10, 32'h10);
        wr(5'h14, 32'h10);
        rd(5'h14, d); check("R6 W1C alarm", d, 32'h3);
        check("R8 irq drops after clear", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_unarmed;
        logic [31:0] d;
        wr(5'h08, 32'hFFFF_FFFF);
        wr(5'h0C, 32'd2);
        wr(5'h00, 32'hFFFF_FFFF);
        wr(5'h04, 32'd0);
        ticks(3);
        rd(5'h14, d); check("R5 all-ones seconds never matches", d & 32'h10, 32'h0);
    endtask

    task automatic t_set_beats_clear;
        logic [31:0] d;
        wr(5'h08, 32'd30);
        wr(5'h0C, 32'd1);
        wr(5'h00, 32'd30);
        wr(5'h04, 32'd0);
        cycle(1'b1, 5'h14, 32'h10, 1'b1);
        rd(5'h14, d); check("R6 match beats clear", d & 32'h10, 32'h10);
        rd(5'h04, d); check("R3 status write does not block tick", d, 32'd1);
        wr(5'h14, 32'h10);
    endtask

    task automatic t_valid_flags;
        logic [31:0] d;
        wr(5'h18, 32'h1);
        check("R8 irq on security flag", {31'h0, irq}, 32'h1);
        rd(5'h18, d); check("R8 ien readback", d, 32'h1);
        wr(5'h14, 32'h2);
        rd(5'h14, d); check("R7 clear invalid only", d, 32'h1);
        check("R8 irq still from security", {31'h0, irq}, 32'h1);
        wr(5'h14, 32'h1);
        rd(5'h14, d); check("R7 clear security", d, 32'h0);
        check("R8 irq low all clear", {31'h0, irq}, 32'h0);
        rd(5'h1C, d); check("R9 unmapped reads zero", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_start_gate();
        t_wrap();
        t_write_priority();
        t_alarm();
        t_unarmed();
        t_set_beats_clear();
        t_valid_flags();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule